// File: doc/BRIEF.md
# Copy-Engine Interrupt Aggregator

This block collects interrupt events from eight copy engines and turns them into per-engine sticky status, a per-engine summary and one combined interrupt line. Each engine reports a copy-complete pulse and an error pulse, and it presents its current ring occupancy. The block compares the occupancy against a high and a low mark for that engine and raises a watermark event when the occupancy crosses either mark.

Software reaches the block through a simple word-addressed register port. For each engine it can read the status bits and clear them by writing ones. It can turn individual interrupt sources on or off through two enable registers, and it can program the two marks. A global summary word shows which engines have an enabled event pending. It also gives the lowest-numbered such engine, because engines are serviced in ascending order. The last engine is meant for polled diagnostics, so all of its interrupt sources start disabled.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all status bits and `irq_o` are 0. Every engine except the last has its copy-complete enable and error enable set. The last engine has every enable clear. All watermark enables are clear. The marks word reads high = all ones and low = 0.
- R2: A pulse on `cc_evt_i[e]` sets status bit 0 of engine e, and a pulse on `err_evt_i[e]` sets status bit 3. Both bits stay set until they are cleared. The status word is at word offset 0.
- R3: Status bit 1 sets when the occupancy goes from below the high mark to at or above it. Status bit 2 sets when the occupancy goes from above the low mark to at or below it. Staying on one side of a mark raises no further event. The marks word is at word offset 3, with the low mark in bits [7:0] and the high mark in bits [15:8].
- R4: Writing to the status word clears exactly the bits written as 1 and leaves every other bit unchanged.
- R5: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R6: The host enable word is at offset 1, with copy-complete in bit 0, high watermark in bit 1 and low watermark in bit 2. The error enable is bit 0 of the word at offset 2. The summary bit of an engine is 1 exactly when one of its status bits has its enable set. A disabled source still records its status.
- R7: The summary word is selected by address bit 5. Bits [7:0] hold the per-engine summary, bits [18:16] hold the lowest engine with its summary bit set, and bit 31 is set when any summary bit is set. Otherwise address bits [4:2] select the engine and bits [1:0] select the word.
- R8: `irq_o` equals the OR of all summary bits one clock earlier.
- R9: Writes to the summary word change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| cc_evt_i | input | 8 | per-engine copy-complete pulses |
| err_evt_i | input | 8 | per-engine error pulses |
| occ_i | input | 64 | per-engine ring occupancy, 8 bits each, engine 0 in the low byte |
| wr_en_i | input | 1 | register write strobe |
| addr_i | input | 6 | register word address |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for `addr_i`, combinational |
| summary_o | output | 8 | per-engine enabled-pending bits |
| irq_o | output | 1 | combined interrupt, registered |

## Verification
The assertions check the following on every cycle, for each engine:
- a copy-complete or error pulse leaves its status bit set in the next cycle, even when a clear arrives at the same time;
- a clear with no event drops the copy-complete bit;
- the copy-complete bit holds its value when neither an event nor a status write touches it;
- the combined line tracks the summary one cycle late.

Some behaviour only the bench scenarios can show:
- watermark crossing detection against programmed marks, in both directions and with no retriggering;
- the reset defaults of the enable registers;
- the gating of summary bits by each enable;
- the lowest-pending index over every non-empty pattern of engines.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NUM_ENG = 8,
  parameter int OCC_W   = 8,
  localparam int IDX_W  = $clog2(NUM_ENG),
  localparam int ADDR_W = IDX_W + 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_ENG-1:0]       cc_evt_i,
  input  logic [NUM_ENG-1:0]       err_evt_i,
  input  logic [NUM_ENG*OCC_W-1:0] occ_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  output logic [NUM_ENG-1:0]       summary_o,
  output logic                     irq_o
);
  logic [NUM_ENG-1:0] st_cc, st_wh, st_wl, st_er;
  logic [NUM_ENG-1:0] en_cc, en_wh, en_wl, en_er;
  logic [NUM_ENG-1:0] wh_evt, wl_evt;
  logic [NUM_ENG-1:0] wr_st, wr_hen, wr_men, wr_mk;
  logic [OCC_W-1:0]   mark_hi [NUM_ENG];
  logic [OCC_W-1:0]   mark_lo [NUM_ENG];
  logic [OCC_W-1:0]   prev_occ [NUM_ENG];
  logic [IDX_W-1:0]   first_idx;

  wire              glob   = addr_i[ADDR_W-1];
  wire [IDX_W-1:0]  a_eng  = addr_i[IDX_W+1:2];
  wire [1:0]        a_word = addr_i[1:0];

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    wire [OCC_W-1:0] occ = occ_i[e*OCC_W +: OCC_W];
    wire sel = wr_en_i && !glob && (a_eng == IDX_W'(e));
    assign wr_st[e]  = sel && (a_word == 2'd0);
    assign wr_hen[e] = sel && (a_word == 2'd1);
    assign wr_men[e] = sel && (a_word == 2'd2);
    assign wr_mk[e]  = sel && (a_word == 2'd3);
    assign wh_evt[e] = (prev_occ[e] < mark_hi[e]) && (occ >= mark_hi[e]);
    assign wl_evt[e] = (prev_occ[e] > mark_lo[e]) && (occ <= mark_lo[e]);
    assign summary_o[e] = |({st_er[e], st_wl[e], st_wh[e], st_cc[e]} &
                            {en_er[e], en_wl[e], en_wh[e], en_cc[e]});

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_cc[e] <= 1'b0;
        st_wh[e] <= 1'b0;
        st_wl[e] <= 1'b0;
        st_er[e] <= 1'b0;
        en_cc[e] <= (e != NUM_ENG - 1);
        en_er[e] <= (e != NUM_ENG - 1);
        en_wh[e] <= 1'b0;
        en_wl[e] <= 1'b0;
        mark_hi[e]  <= '1;
        mark_lo[e]  <= '0;
        prev_occ[e] <= '0;
      end else begin
        prev_occ[e] <= occ;
        st_cc[e] <= cc_evt_i[e]  | (st_cc[e] & ~(wr_st[e] & wdata_i[0]));
        st_wh[e] <= wh_evt[e]    | (st_wh[e] & ~(wr_st[e] & wdata_i[1]));
        st_wl[e] <= wl_evt[e]    | (st_wl[e] & ~(wr_st[e] & wdata_i[2]));
        st_er[e] <= err_evt_i[e] | (st_er[e] & ~(wr_st[e] & wdata_i[3]));
        if (wr_hen[e]) begin
          en_cc[e] <= wdata_i[0];
          en_wh[e] <= wdata_i[1];
          en_wl[e] <= wdata_i[2];
        end
        if (wr_men[e]) en_er[e] <= wdata_i[0];
        if (wr_mk[e]) begin
          mark_lo[e] <= wdata_i[0 +: OCC_W];
          mark_hi[e] <= wdata_i[OCC_W +: OCC_W];
        end
      end
    end
  end

  always_comb begin
    first_idx = '0;
    for (int e = NUM_ENG - 1; e >= 0; e--)
      if (summary_o[e]) first_idx = IDX_W'(e);
  end

  always_comb begin
    rdata_o = '0;
    if (glob) begin
      rdata_o[NUM_ENG-1:0] = summary_o;
      rdata_o[16 +: IDX_W] = first_idx;
      rdata_o[31]          = |summary_o;
    end else begin
      case (a_word)
        2'd0: rdata_o[3:0] = {st_er[a_eng], st_wl[a_eng], st_wh[a_eng], st_cc[a_eng]};
        2'd1: rdata_o[2:0] = {en_wl[a_eng], en_wh[a_eng], en_cc[a_eng]};
        2'd2: rdata_o[0]   = en_er[a_eng];
        default: begin
          rdata_o[0 +: OCC_W]     = mark_lo[a_eng];
          rdata_o[OCC_W +: OCC_W] = mark_hi[a_eng];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= |summary_o;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NUM_ENG = 8,
  localparam int IDX_W  = $clog2(NUM_ENG),
  localparam int ADDR_W = IDX_W + 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_ENG-1:0] cc_evt_i,
  input logic [NUM_ENG-1:0] err_evt_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic [NUM_ENG-1:0] st_cc,
  input logic [NUM_ENG-1:0] st_er,
  input logic [NUM_ENG-1:0] summary_o,
  input logic               irq_o
);
  for (genvar e = 0; e < NUM_ENG; e++) begin : g_chk
    wire st_wr = wr_en_i && !addr_i[ADDR_W-1] && (addr_i[IDX_W+1:2] == IDX_W'(e)) &&
                 (addr_i[1:0] == 2'd0);

    // R2 R5
    cc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cc_evt_i[e] |=> st_cc[e]);

    // R2 R5
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_evt_i[e] |=> st_er[e]);

    // R4
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && wdata_i[0] && !cc_evt_i[e]) |=> !st_cc[e]);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_wr && !cc_evt_i[e]) |=> $stable(st_cc[e]));
  end

  // R8
  irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|summary_o));
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_ENG(NUM_ENG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cc_evt_i(cc_evt_i), .err_evt_i(err_evt_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .st_cc(st_cc), .st_er(st_er), .summary_o(summary_o), .irq_o(irq_o)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] cc_evt = '0, err_evt = '0;
  logic [N*8-1:0] occ = '0;
  logic wr_en = 0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] summary;
  logic irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .cc_evt_i(cc_evt), .err_evt_i(err_evt), .occ_i(occ),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .summary_o(summary), .irq_o(irq));

  function automatic logic [5:0] ea(input int e, input int w);
    return {1'b0, 3'(e), 2'(w)};
  endfunction
  localparam logic [5:0] SUM_A = 6'b100000;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_cc(input logic [N-1:0] m);
    @(negedge clk); cc_evt = m;
    @(negedge clk); cc_evt = '0;
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset defaults
    chk(irq == 0, "R1 irq", {31'b0, irq}, 0);
    for (int e = 0; e < N; e++) begin
      rd_chk(ea(e, 0), 0, "R1 status");
      rd_chk(ea(e, 1), (e == N-1) ? 0 : 1, "R1 host enable");
      rd_chk(ea(e, 2), (e == N-1) ? 0 : 1, "R1 error enable");
      rd_chk(ea(e, 3), 32'h0000FF00, "R1 marks");
    end

    // R2 R6 last engine disabled: status recorded, no summary
    pulse_cc(8'h80);
    rd_chk(ea(7, 0), 1, "R2 cc status on disabled engine");
    rd_chk(SUM_A, 0, "R6 disabled source gives no summary");
    chk(irq == 0, "R6 irq stays low", {31'b0, irq}, 0);
    wr(ea(7, 1), 1);
    rd_chk(SUM_A, 32'h8007_0080, "R6 enabling exposes pending status");
    wr(ea(7, 0), 1);

    // R2 R4 error and independent clear
    @(negedge clk); err_evt = 8'h08; cc_evt = 8'h08;
    @(negedge clk); err_evt = 0; cc_evt = 0;
    rd_chk(ea(3, 0), 32'h9, "R2 cc and err status");
    wr(ea(3, 0), 1);
    rd_chk(ea(3, 0), 32'h8, "R4 clear cc leaves err");
    wr(ea(3, 2), 0);
    rd_chk(SUM_A, 0, "R6 error enable off gates summary");
    wr(ea(3, 2), 1);
    rd_chk(SUM_A, 32'h8003_0008, "R6 error enable on");
    wr(ea(3, 0), 8);
    rd_chk(ea(3, 0), 0, "R4 clear err");

    // R5 event wins over simultaneous clear
    pulse_cc(8'h08);
    @(negedge clk); wr_en = 1; addr = ea(3, 0); wdata = 1; cc_evt = 8'h08;
    @(negedge clk); wr_en = 0; cc_evt = 0;
    rd_chk(ea(3, 0), 1, "R5 event wins");
    wr(ea(3, 0), 1);
    rd_chk(ea(3, 0), 0, "R4 plain clear");

    // R9 summary writes ignored
    pulse_cc(8'h04);
    wr(SUM_A, 32'hFFFF_FFFF);
    rd_chk(ea(2, 0), 1, "R9 status unchanged by summary write");
    rd_chk(ea(2, 1), 1, "R9 enable unchanged by summary write");
    wr(ea(2, 0), 1);

    // R3 watermark sweep on engine 2, low=10 high=20
    wr(ea(2, 3), (20 << 8) | 10);
    wr(ea(2, 1), 7);
    begin
      int prev = 0;
      logic hi_seen = 0, lo_seen = 0;
      int hi_cnt = 0;
      for (int v = 0; v <= 30; v++) begin
        @(negedge clk); occ[16 +: 8] = 8'(v);
        if (prev < 20 && v >= 20) begin hi_seen = 1; hi_cnt++; end
        if (prev > 10 && v <= 10) lo_seen = 1;
        prev = v;
        rd(ea(2, 0), d);
        chk(d == {29'b0, lo_seen, hi_seen, 1'b0}, "R3 rising sweep", d, {29'b0, lo_seen, hi_seen, 1'b0});
      end
      chk(hi_cnt == 1, "R3 single high crossing", hi_cnt, 1);
      wr(ea(2, 0), 2);
      hi_seen = 0;
      for (int v = 30; v >= 0; v--) begin
        @(negedge clk); occ[16 +: 8] = 8'(v);
        if (prev > 10 && v <= 10) lo_seen = 1;
        prev = v;
        rd(ea(2, 0), d);
        chk(d == {29'b0, lo_seen, 2'b0}, "R3 falling sweep", d, {29'b0, lo_seen, 2'b0});
      end
      rd_chk(SUM_A, 32'h8002_0004, "R6 low watermark enable");
      wr(ea(2, 0), 4);
    end

    // R7 R8 every non-empty engine pattern
    for (int p = 1; p < 256; p++) begin
      int lo = 0;
      logic [31:0] exp;
      for (int e = N - 1; e >= 0; e--) if (p[e]) lo = e;
      exp = {1'b1, 12'b0, 3'(lo), 8'b0, 8'(p)};
      pulse_cc(8'(p));
      chk(irq == 0, "R8 irq delayed one cycle", {31'b0, irq}, 0);
      rd(SUM_A, d);
      chk(d == exp, "R7 summary word", d, exp);
      chk(irq == 1, "R8 irq set", {31'b0, irq}, 1);
      for (int e = 0; e < N; e++) if (p[e]) wr(ea(e, 0), 1);
      rd(SUM_A, d);
      chk(irq == 0, "R8 irq cleared", {31'b0, irq}, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule